// File: doc/BRIEF.md
# Frame writeback capture controller

The block sequences the capture of one composited frame into system memory. Software programs a destination base address, a line pitch and the frame dimensions through a small register window, then sets the start bit in the control word. While a frame is in progress the block takes 32-bit pixel words from an upstream valid/ready stream. It forwards each word as a memory write request whose address is the frame base plus the line index times the pitch plus four times the word index within the line.

The block counts the lines that have been fully committed to memory and shows busy status in the control word. A control write can cut a frame short, or hold the pixel path still by powering down the line memory. When its enable bit is set, a level interrupt reports that the block has gone idle. Software acknowledges that interrupt by clearing the enable bit. Base, pitch and dimensions are captured at start, so software may reprogram them for the next frame while the current one runs.

Top module: `fwb_capture`

## Requirements
- R1: After reset the base, pitch, dimension and progress registers read 0, the control word reads 0x5440_0000, and mem_valid_o, pix_ready_o and irq_o are 0.
- R2: Register offsets are: base 0x00, pitch 0x04, dimensions 0x08 (height in bits 31:16, width in 32-bit words in bits 15:0), control 0x0C and progress 0x10. The base keeps bits 1:0 at zero and the pitch keeps bits 3:0 at zero. Any other offset reads 0.
- R3: The control word reads back as follows: bits 31:24 are 0x54, bits 23:22 are 0x1, bit 21 is the stored power-down bit, bit 2 is the stored interrupt enable and bit 1 is busy. Bits 0 (start) and 14 (abort) and every other bit read 0.
- R4: A control write with bit 0 set while the block is idle and both dimensions are nonzero makes busy read 1 from the next cycle and clears progress to 0. If the width or the height is 0, the write clears progress, leaves busy at 0 and marks the frame done at once.
- R5: Word k of line n is written at (base + n*pitch + 4*k) modulo 2^ADDR_W. The data is the accepted pixel word, in stream order.
- R6: Progress increments once the last word of a line is accepted. After `height` lines the block drops busy, and progress holds `height` until the next start.
- R7: A start written while busy is ignored. Writes to base, pitch or dimensions during a frame take effect only at the next start.
- R8: A control write with bit 14 set while busy drops busy in the next cycle. No further write request is issued and progress holds. The same write while idle has no effect.
- R9: irq_o equals a done flag ANDed with the interrupt enable. The flag is set when a frame completes or is aborted, and is cleared by a start. Clearing the enable drops irq_o.
- R10: While power-down is set, pix_ready_o and mem_valid_o stay 0 and progress does not move. Clearing the bit resumes the frame where it stopped.
- R11: While a write request is held off by mem_ready_i, its address stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte offset for both read and write |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| pix_valid_i | input | 1 | Pixel word available |
| pix_data_i | input | 32 | Pixel word |
| pix_ready_o | output | 1 | Pixel word taken this cycle |
| mem_valid_o | output | 1 | Write request valid |
| mem_addr_o | output | ADDR_W | Write byte address |
| mem_data_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Memory accepts the request |
| irq_o | output | 1 | Idle interrupt, level |

## Verification
The bench builds the block with ADDR_W = 24. A frame whose base sits just below 2^24 then wraps its addresses inside the run, which exercises the modulo rule of R5 without long frames. The dimension fields keep their full 16-bit width, and small programmed sizes keep frames short. A pseudo-random memory ready pattern forces stalls in the middle of a line and at line ends. Register rewrites, a start pulse, power-down and abort are all placed while a frame is in flight.

// File: rtl/fwb_pkg.sv
package fwb_pkg;
  localparam int REG_AW = 5;
  localparam int DIM_W  = 16;

  localparam logic [REG_AW-1:0] OFF_BASE  = 5'h00;
  localparam logic [REG_AW-1:0] OFF_PITCH = 5'h04;
  localparam logic [REG_AW-1:0] OFF_DIM   = 5'h08;
  localparam logic [REG_AW-1:0] OFF_CTRL  = 5'h0C;
  localparam logic [REG_AW-1:0] OFF_PROG  = 5'h10;

  localparam int CB_GO     = 0;
  localparam int CB_BUSY   = 1;
  localparam int CB_IRQ_EN = 2;
  localparam int CB_ABORT  = 14;
  localparam int CB_PWRDN  = 21;

  localparam logic [7:0] ID_TAG = 8'h54;
  localparam logic [1:0] ID_REV = 2'b01;

  typedef struct packed {
    logic [31:0]      base;
    logic [31:0]      pitch;
    logic [DIM_W-1:0] height;
    logic [DIM_W-1:0] width;
  } frame_cfg_t;
endpackage

// File: rtl/fwb_regfile.sv
module fwb_regfile
  import fwb_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              busy_i,
  input  logic [DIM_W-1:0]  progress_i,
  output frame_cfg_t        cfg_o,
  output logic              irq_en_o,
  output logic              pwrdn_o,
  output logic              start_o,
  output logic              abort_o
);
  logic [ADDR_W-1:0] base_q;
  logic [31:0]       pitch_q;
  logic [DIM_W-1:0]  width_q, height_q;
  logic              irq_en_q, pwrdn_q;
  logic [31:0]       base_ext, ctrl_rd;

  logic ctrl_wr;
  assign ctrl_wr = wr_i && (addr_i == OFF_CTRL);
  assign start_o = ctrl_wr && wdata_i[CB_GO];
  assign abort_o = ctrl_wr && wdata_i[CB_ABORT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      pitch_q  <= '0;
      width_q  <= '0;
      height_q <= '0;
      irq_en_q <= 1'b0;
      pwrdn_q  <= 1'b0;
    end else if (wr_i) begin
      unique case (addr_i)
        OFF_BASE:  base_q  <= wdata_i[ADDR_W-1:0] & ~ADDR_W'(3);
        OFF_PITCH: pitch_q <= wdata_i & ~32'hF;
        OFF_DIM: begin
          height_q <= wdata_i[31:16];
          width_q  <= wdata_i[15:0];
        end
        OFF_CTRL: begin
          irq_en_q <= wdata_i[CB_IRQ_EN];
          pwrdn_q  <= wdata_i[CB_PWRDN];
        end
        default: ;
      endcase
    end
  end

  generate
    if (ADDR_W < 32) begin : g_base_pad
      assign base_ext = {{(32-ADDR_W){1'b0}}, base_q};
    end else begin : g_base_full
      assign base_ext = base_q;
    end
  endgenerate

  always_comb begin
    ctrl_rd            = '0;
    ctrl_rd[31:24]     = ID_TAG;
    ctrl_rd[23:22]     = ID_REV;
    ctrl_rd[CB_PWRDN]  = pwrdn_q;
    ctrl_rd[CB_IRQ_EN] = irq_en_q;
    ctrl_rd[CB_BUSY]   = busy_i;
  end

  always_comb begin
    unique case (addr_i)
      OFF_BASE:  rdata_o = base_ext;
      OFF_PITCH: rdata_o = pitch_q;
      OFF_DIM:   rdata_o = {height_q, width_q};
      OFF_CTRL:  rdata_o = ctrl_rd;
      OFF_PROG:  rdata_o = {{(32-DIM_W){1'b0}}, progress_i};
      default:   rdata_o = '0;
    endcase
  end

  assign cfg_o.base   = base_ext;
  assign cfg_o.pitch  = pitch_q;
  assign cfg_o.height = height_q;
  assign cfg_o.width  = width_q;
  assign irq_en_o     = irq_en_q;
  assign pwrdn_o      = pwrdn_q;
endmodule

// File: rtl/fwb_frame_seq.sv
module fwb_frame_seq
  import fwb_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  frame_cfg_t        cfg_i,
  input  logic              pwrdn_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DIM_W-1:0]  progress_o,
  input  logic              pix_valid_i,
  output logic              pix_ready_o,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o
);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);

  logic              busy_q, done_q;
  logic [DIM_W-1:0]  w_q, h_q, word_cnt_q, line_cnt_q;
  logic [ADDR_W-1:0] pitch_q, line_base_q, word_addr_q, next_line;
  logic              run, beat, last_word, last_line, zero_dim;

  assign run         = busy_q && !pwrdn_i;
  assign pix_ready_o = run && mem_ready_i;
  assign mem_valid_o = run && pix_valid_i;
  assign beat        = mem_valid_o && mem_ready_i;
  assign last_word   = (word_cnt_q == w_q - 1'b1);
  assign last_line   = (line_cnt_q == h_q - 1'b1);
  assign next_line   = line_base_q + pitch_q;
  assign zero_dim    = (cfg_i.width == '0) || (cfg_i.height == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      w_q         <= '0;
      h_q         <= '0;
      word_cnt_q  <= '0;
      line_cnt_q  <= '0;
      pitch_q     <= '0;
      line_base_q <= '0;
      word_addr_q <= '0;
    end else if (busy_q) begin
      if (abort_i) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else if (beat) begin
        if (last_word) begin
          word_cnt_q  <= '0;
          line_cnt_q  <= line_cnt_q + 1'b1;
          line_base_q <= next_line;
          word_addr_q <= next_line;
          if (last_line) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end else begin
          word_cnt_q  <= word_cnt_q + 1'b1;
          word_addr_q <= word_addr_q + WORD_STEP;
        end
      end
    end else if (start_i) begin
      busy_q      <= !zero_dim;
      done_q      <= zero_dim;
      w_q         <= cfg_i.width;
      h_q         <= cfg_i.height;
      word_cnt_q  <= '0;
      line_cnt_q  <= '0;
      pitch_q     <= cfg_i.pitch[ADDR_W-1:0];
      line_base_q <= cfg_i.base[ADDR_W-1:0];
      word_addr_q <= cfg_i.base[ADDR_W-1:0];
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign progress_o = line_cnt_q;
  assign mem_addr_o = word_addr_q;

  AST_ABORT_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && abort_i) |=> (!busy_q && !mem_valid_o)) else $error("abort"); // R8
  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && start_i) |=> (line_cnt_q == '0 && (busy_q != done_q))) else $error("start"); // R4
  AST_PROGRESS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (line_cnt_q < h_q)) else $error("progress"); // R6
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i && !abort_i) |=> $stable(mem_addr_o)) else $error("stall"); // R11
  AST_PWRDN_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwrdn_i && busy_q) |=> $stable(line_cnt_q)) else $error("pwrdn"); // R10
endmodule

// File: rtl/fwb_capture.sv
module fwb_capture
  import fwb_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [4:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              pix_valid_i,
  input  logic [31:0]       pix_data_i,
  output logic              pix_ready_o,
  output logic              mem_valid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_data_o,
  input  logic              mem_ready_i,
  output logic              irq_o
);
  frame_cfg_t       cfg;
  logic             irq_en, pwrdn, start, abort, busy, done;
  logic [DIM_W-1:0] progress;

  fwb_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .busy_i     (busy),
    .progress_i (progress),
    .cfg_o      (cfg),
    .irq_en_o   (irq_en),
    .pwrdn_o    (pwrdn),
    .start_o    (start),
    .abort_o    (abort)
  );

  fwb_frame_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .abort_i     (abort),
    .cfg_i       (cfg),
    .pwrdn_i     (pwrdn),
    .busy_o      (busy),
    .done_o      (done),
    .progress_o  (progress),
    .pix_valid_i (pix_valid_i),
    .pix_ready_o (pix_ready_o),
    .mem_valid_o (mem_valid_o),
    .mem_ready_i (mem_ready_i),
    .mem_addr_o  (mem_addr_o)
  );

  assign mem_data_o = pix_data_i;
  assign irq_o      = done && irq_en;

  AST_IRQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !busy) else $error("irq while busy"); // R9
endmodule

// File: tb/tb_fwb_capture.sv
module tb_fwb_capture;
  localparam int AW = 24;
  localparam logic [AW-1:0] AMASK = '1;
  localparam logic [4:0] A_BASE = 5'h00, A_PITCH = 5'h04, A_DIM = 5'h08,
                         A_CTRL = 5'h0C, A_PROG = 5'h10;
  localparam logic [31:0] GO = 32'h1, EI = 32'h4, ABT = 32'h4000, PD = 32'h20_0000;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [4:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic pix_valid = 0, pix_ready;
  logic [31:0] pix_data;
  logic mem_valid, mem_ready = 1, irq;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_data;

  int vectors = 0, errors = 0;
  int acc_count = 0, exp_idx = 0;
  logic [AW+31:0] exp_q[$];
  bit rand_ready = 0, saw_write = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  fwb_capture #(.ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .pix_valid_i(pix_valid),
    .pix_data_i(pix_data), .pix_ready_o(pix_ready), .mem_valid_o(mem_valid),
    .mem_addr_o(mem_addr), .mem_data_o(mem_data), .mem_ready_i(mem_ready), .irq_o(irq));

  assign pix_data = 32'hD000_0000 + acc_count;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard pop on every accepted beat
  always @(negedge clk) begin
    if (mem_valid) saw_write = 1;
    if (rst_n && mem_valid && mem_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, "R5 unexpected write", {8'h0, mem_addr, mem_data}, 0);
      end else begin
        logic [AW+31:0] e;
        e = exp_q.pop_front();
        chk(e == {mem_addr, mem_data}, "R5 write beat", {8'h0, mem_addr, mem_data}, {8'h0, e});
      end
      acc_count++;
    end
  end

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready = rand_ready ? lfsr[0] : 1'b1;
  end

  task automatic push_frame(input logic [31:0] base, input logic [31:0] pitch, input int w, input int h);
    for (int n = 0; n < h; n++)
      for (int k = 0; k < w; k++) begin
        logic [AW-1:0] a;
        a = AW'(base + n * pitch + 4 * k) & AMASK;
        exp_q.push_back({a, 32'hD000_0000 + exp_idx});
        exp_idx++;
      end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk); #1;
      rd(A_CTRL, v);
      if (!v[1]) return;
    end
    chk(0, "R6 frame never finished", 1, 0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, p;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rd(A_CTRL, v);  chk(v == 32'h5440_0000, "R1 ctrl reset", v, 32'h5440_0000);
    rd(A_PROG, v);  chk(v == 0, "R1 progress reset", v, 0);
    rd(A_BASE, v);  chk(v == 0, "R1 base reset", v, 0);
    chk(!irq && !mem_valid && !pix_ready, "R1 outputs reset", {irq, mem_valid, pix_ready}, 0);
    pix_valid = 1;
    repeat (3) @(posedge clk);
    #2 chk(!mem_valid && !pix_ready, "R1 idle no requests", {mem_valid, pix_ready}, 0);

    // R2 register map and alignment
    wr(A_BASE, 32'h0000_1003);  rd(A_BASE, v);  chk(v == 32'h1000, "R2 base align", v, 32'h1000);
    wr(A_PITCH, 32'h0000_0047); rd(A_PITCH, v); chk(v == 32'h40, "R2 pitch align", v, 32'h40);
    wr(A_DIM, 32'h0004_0003);   rd(A_DIM, v);   chk(v == 32'h0004_0003, "R2 dims", v, 32'h0004_0003);
    rd(5'h14, v); chk(v == 0, "R2 unmapped", v, 0);

    // R3 readback; R8 abort while idle has no effect
    wr(A_CTRL, 32'hFFFF_FFFE);
    rd(A_CTRL, v); chk(v == 32'h5460_0004, "R3 ctrl readback", v, 32'h5460_0004);
    chk(!mem_valid, "R8 abort idle no write", mem_valid, 0);
    wr(A_CTRL, 0);
    rd(A_CTRL, v); chk(v == 32'h5440_0000, "R3 ctrl cleared", v, 32'h5440_0000);

    // Frame A: base 0x100 pitch 0x40 3x4
    wr(A_BASE, 32'h100); wr(A_PITCH, 32'h40);
    push_frame(32'h100, 32'h40, 3, 4);
    wr(A_CTRL, GO | EI);
    rd(A_CTRL, v); chk(v[1], "R4 busy after start", v[1], 1);
    rd(A_PROG, v); chk(v == 0, "R4 progress cleared", v, 0);
    wait_idle();
    rd(A_PROG, v); chk(v == 4, "R6 progress at end", v, 4);
    chk(irq, "R9 irq on idle", irq, 1);
    chk(exp_q.size() == 0, "R5 frame A complete", exp_q.size(), 0);
    wr(A_CTRL, 0);
    chk(!irq, "R9 irq cleared by enable", irq, 0);

    // Frame B: wrap near top of address space, random stalls, R7 rewrites
    rand_ready = 1;
    wr(A_BASE, 32'hFF_FFC0); wr(A_PITCH, 32'h20); wr(A_DIM, 32'h0003_0004);
    push_frame(32'hFF_FFC0, 32'h20, 4, 3);
    wr(A_CTRL, GO);
    wr(A_BASE, 32'h2000);
    wr(A_CTRL, GO);
    rd(A_CTRL, v); chk(v[1], "R7 still busy", v[1], 1);
    wait_idle();
    rd(A_PROG, v); chk(v == 3, "R7 progress not restarted", v, 3);
    chk(exp_q.size() == 0, "R5 frame B wrap complete", exp_q.size(), 0);
    rand_ready = 0;

    // Frame C: new base applies; power-down pause
    push_frame(32'h2000, 32'h20, 4, 3);
    wr(A_CTRL, GO | EI);
    wr(A_CTRL, PD | EI);
    rd(A_PROG, p);
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #2;
      chk(!mem_valid && !pix_ready, "R10 paused", {mem_valid, pix_ready}, 0);
    end
    rd(A_PROG, v); chk(v == p, "R10 progress frozen", v, p);
    rd(A_CTRL, v); chk(v[1], "R10 busy held", v[1], 1);
    wr(A_CTRL, EI);
    wait_idle();
    rd(A_PROG, v); chk(v == 3, "R10 resumed to end", v, 3);
    chk(exp_q.size() == 0, "R7 frame C at new base", exp_q.size(), 0);

    // Frame D: abort mid-frame
    wr(A_BASE, 32'h400); wr(A_PITCH, 32'h40); wr(A_DIM, 32'h0008_0008);
    push_frame(32'h400, 32'h40, 8, 8);
    wr(A_CTRL, GO);
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); #1; rd(A_PROG, v);
      if (v >= 2) break;
    end
    wr(A_CTRL, ABT | EI);
    rd(A_CTRL, v); chk(!v[1], "R8 busy dropped", v[1], 0);
    chk(irq, "R9 irq after abort", irq, 1);
    exp_q.delete();
    exp_idx = acc_count;
    rd(A_PROG, p);
    saw_write = 0;
    repeat (20) @(posedge clk);
    #2 chk(!saw_write, "R8 no writes after abort", saw_write, 0);
    rd(A_PROG, v); chk(v == p && p < 8, "R8 progress held", v, p);

    // Zero height: done at once, no busy
    wr(A_DIM, 32'h0000_0005);
    wr(A_CTRL, GO | EI);
    rd(A_CTRL, v); chk(!v[1], "R4 zero dim not busy", v[1], 0);
    rd(A_PROG, v); chk(v == 0, "R4 zero dim progress", v, 0);
    chk(irq, "R4 zero dim done", irq, 1);
    repeat (5) @(posedge clk);
    #2 chk(!mem_valid, "R4 zero dim no write", mem_valid, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule